// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter, four bits wide by default, that steps up or down by one on each rising clock edge while both of its active-low count enables are asserted. A synchronous parallel load, also active low, replaces the count with a data word at the next edge. The load wins over counting. Both directions wrap modulo 2^WIDTH.

For cascading, the carry-in enable is fed forward into an active-low terminal-count output. That output asserts only while the carry-in enable is asserted and the count sits at its top value when counting up, or at zero when counting down. The output is combinational, with no register. Wiring each stage's terminal count to the next stage's carry-in enable therefore builds a wide counter in which every stage advances on the same edge. Q bit 0 is the least significant bit, and data bit 0 loads into it.

Top module: `cascade_counter`

## Requirements
- R1: When loadN is low at a rising edge, the count takes the value of dataIn on that edge, with dataIn bit 0 going to count bit 0.
- R2: Loading takes effect whatever the levels of enpN, entN and upDn. A load with both enables asserted yields dataIn, not a counted value.
- R3: With loadN high, enpN low, entN low and upDn high (1 = up), the count rises by one per edge and wraps from the top value (15 at default width) to 0.
- R4: With loadN high, enpN low, entN low and upDn low (0 = down), the count falls by one per edge and wraps from 0 to the top value.
- R5: With loadN high and either enpN or entN high, the count holds its value across edges.
- R6: With upDn high, tcN is low exactly when entN is low and the count equals the top value.
- R7: With upDn low, tcN is low exactly when entN is low and the count equals 0.
- R8: tcN is high whenever entN is high. It follows entN, upDn and the count without waiting for a clock edge.
- R9: Stages chained through tcN into the next stage's entN, with shared enpN, upDn and loadN, behave as one counter of their combined width in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| upDn | input | 1 | Direction select: 1 up, 0 down |
| loadN | input | 1 | Synchronous parallel load, active low |
| enpN | input | 1 | Parallel count enable, active low |
| entN | input | 1 | Carry-in count enable, active low; gates tcN |
| dataIn | input | WIDTH | Value to load |
| count | output | WIDTH | Current count |
| tcN | output | 1 | Terminal count, active low, combinational |

## Verification
Load and count can fall on the same edge. The bench provokes this by pulling loadN low while both enables are asserted and the count sits at a wrap point. The next count must equal dataIn, not the incremented or decremented value. Terminal count also coincides with a count step in a cascade, because a lower stage wraps on the same edge that its tcN advances the upper stage. A chained three-stage counter is run across its carry and borrow boundaries and compared each cycle against a 12-bit model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
  } cntStrobes_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic        clk,
  input  logic        upDn,
  input  logic        loadN,
  input  logic        enpN,
  input  logic        entN,
  output cntStrobes_t strobes
);
  logic countEn;

  always_comb begin
    countEn      = !enpN && !entN;
    strobes.load = !loadN;
    strobes.inc  = loadN && countEn && upDn;
    strobes.dec  = loadN && countEn && !upDn;
  end

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!pastValid)
    $onehot0({strobes.load, strobes.inc, strobes.dec}));
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  cntStrobes_t      strobes,
  input  logic             upDn,
  input  logic             entN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             tcN
);
  localparam logic [WIDTH-1:0] ONE    = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOPVAL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] countNext;
  logic             atEnd;

  always_comb begin
    if (strobes.load)     countNext = dataIn;
    else if (strobes.inc) countNext = count + ONE;
    else if (strobes.dec) countNext = count - ONE;
    else                  countNext = count;
  end

  always_ff @(posedge clk) count <= countNext;

  always_comb begin
    atEnd = upDn ? (count == TOPVAL) : (count == '0);
    tcN   = !(atEnd && !entN);
  end

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R3
  count_up_chk: assert property (@(posedge clk) disable iff (!pastValid)
    $past(strobes.inc) |-> count == $past(count) + ONE);
  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!pastValid)
    $past(strobes.dec) |-> count == $past(count) - ONE);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!pastValid)
    $past(!strobes.load && !strobes.inc && !strobes.dec) |-> $stable(count));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             upDn,
  input  logic             loadN,
  input  logic             enpN,
  input  logic             entN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             tcN
);
  cntStrobes_t strobes;

  cnt_ctrl uCtrl (
    .clk(clk), .upDn(upDn), .loadN(loadN), .enpN(enpN), .entN(entN),
    .strobes(strobes)
  );

  cnt_datapath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .strobes(strobes), .upDn(upDn), .entN(entN),
    .dataIn(dataIn), .count(count), .tcN(tcN)
  );

  logic pastValid = 1'b0;
  always_ff @(posedge clk) pastValid <= 1'b1;

  // R1
  load_value_chk: assert property (@(posedge clk) disable iff (!pastValid)
    $past(!loadN) |-> count == $past(dataIn));
  // R8
  tc_gated_chk: assert property (@(posedge clk) disable iff (!pastValid)
    entN |-> tcN);
  // R6
  tc_up_chk: assert property (@(posedge clk) disable iff (!pastValid)
    (upDn && !entN && count == {WIDTH{1'b1}}) |-> !tcN);
  // R7
  tc_down_chk: assert property (@(posedge clk) disable iff (!pastValid)
    (!upDn && !entN && count == '0) |-> !tcN);
endmodule

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        upDn = 1'b1, loadN = 1'b1, enpN = 1'b1, entN = 1'b1;
  logic [11:0] dataIn = '0;
  logic [3:0]  c0, c1, c2;
  logic        tc0, tc1, tc2;
  int          vecs = 0, bad = 0;
  bit          done = 0;

  cascade_counter dut (.clk(clk), .upDn(upDn), .loadN(loadN), .enpN(enpN),
    .entN(entN), .dataIn(dataIn[3:0]), .count(c0), .tcN(tc0));
  cascade_counter s1 (.clk(clk), .upDn(upDn), .loadN(loadN), .enpN(enpN),
    .entN(tc0), .dataIn(dataIn[7:4]), .count(c1), .tcN(tc1));
  cascade_counter s2 (.clk(clk), .upDn(upDn), .loadN(loadN), .enpN(enpN),
    .entN(tc1), .dataIn(dataIn[11:8]), .count(c2), .tcN(tc2));

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, let one rising edge pass, sample 1 ns later
  task automatic tick(logic u, logic ld, logic p, logic t, logic [11:0] d);
    @(negedge clk);
    upDn = u; loadN = ld; enpN = p; entN = t; dataIn = d;
    @(posedge clk); #1;
  endtask

  task automatic t_load;
    tick(1, 0, 1, 1, 12'h5A3);
    chk("R1 load all stages", {c2, c1, c0}, 12'h5A3);
    tick(0, 0, 1, 1, 12'h001);
    chk("R1 bit0 to count bit0", {8'h0, c0}, 12'h001);
  endtask

  task automatic t_priority;
    tick(1, 0, 1, 1, 12'h00F);
    tick(1, 0, 0, 0, 12'h003);
    chk("R2 load beats up at 15", {8'h0, c0}, 12'h003);
    tick(0, 0, 1, 1, 12'h000);
    tick(0, 0, 0, 0, 12'h009);
    chk("R2 load beats down at 0", {8'h0, c0}, 12'h009);
  endtask

  task automatic t_wrap;
    tick(1, 0, 1, 1, 12'h00E);
    tick(1, 1, 0, 0, 12'h000);
    chk("R3 up 14->15", {8'h0, c0}, 12'h00F);
    tick(1, 1, 0, 0, 12'h000);
    chk("R3 up wrap 15->0", {8'h0, c0}, 12'h000);
    tick(0, 1, 0, 0, 12'h000);
    chk("R4 down wrap 0->15", {8'h0, c0}, 12'h00F);
    tick(0, 1, 0, 0, 12'h000);
    chk("R4 down 15->14", {8'h0, c0}, 12'h00E);
  endtask

  task automatic t_hold;
    tick(1, 0, 1, 1, 12'h007);
    tick(1, 1, 1, 0, 12'h000);
    chk("R5 hold enp high", {8'h0, c0}, 12'h007);
    tick(0, 1, 0, 1, 12'h000);
    chk("R5 hold ent high", {8'h0, c0}, 12'h007);
    tick(1, 1, 1, 1, 12'h000);
    chk("R5 hold both high", {8'h0, c0}, 12'h007);
  endtask

  task automatic t_tc;
    tick(1, 0, 1, 1, 12'h00F);
    @(negedge clk); entN = 0; upDn = 1; #1;
    chk("R6 tc low at 15 up", {11'h0, tc0}, 12'h000);
    entN = 1; #1;
    chk("R8 tc gated by ent", {11'h0, tc0}, 12'h001);
    entN = 0; upDn = 0; #1;
    chk("R7 tc high at 15 down", {11'h0, tc0}, 12'h001);
    tick(0, 0, 1, 0, 12'h000);
    chk("R7 tc low at 0 down", {11'h0, tc0}, 12'h000);
    upDn = 1; #1;
    chk("R6 tc high at 0 up", {11'h0, tc0}, 12'h001);
    tick(1, 0, 1, 0, 12'h005);
    chk("R6 tc high mid count", {11'h0, tc0}, 12'h001);
  endtask

  task automatic t_cascade(logic u, logic [11:0] start, int steps);
    logic [11:0] exp;
    tick(u, 0, 1, 1, start);
    exp = start;
    chk("R9 cascade load", {c2, c1, c0}, exp);
    for (int i = 0; i < steps; i++) begin
      tick(u, 1, 0, 0, 12'h000);
      exp = u ? exp + 12'd1 : exp - 12'd1;
      chk(u ? "R9 cascade up" : "R9 cascade down", {c2, c1, c0}, exp);
    end
  endtask

  initial begin
    t_load();
    t_priority();
    t_wrap();
    t_hold();
    t_tc();
    t_cascade(1, 12'hFF8, 20);
    t_cascade(0, 12'h008, 20);
    t_cascade(1, 12'h0EC, 40);
    t_cascade(0, 12'h110, 40);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      vecs++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule